// File: doc/BRIEF.md
# IDE Channel Register Access Decoder

This block sits between a host I/O port and the registers of one IDE channel. The host reaches the channel through two windows. The task-file window is eight bytes long. The control window is four bytes long. Each host access carries a window select, a byte offset, a size code of 1, 2 or 4 bytes, and a read or write strobe. The decoder decides whether the combination of size and offset is legal. A legal access is turned into a single strobe on a simple drive-side register port, with the drive address, the transfer width and the write data. An illegal access never reaches the drive port. An illegal write simply disappears. An illegal read returns all ones across the requested width.

Read data returns through a register stage one clock after the host strobe. It is zero-extended above the access width. Both windows are little-endian: host byte 0 travels in bits 7:0.

A small register-backed drive model, `ide_drv_model`, ships with the RTL so that a bench can close the loop. It holds:
- a 32-bit data-port register;
- seven task-file bytes;
- a device-control byte.

Its status byte is task-file byte 7, and the alternate-status read returns that same byte.

Top module: `ide_chan_decoder`

## Requirements
- R1: A 1-byte task-file access at any offset 0..7 raises one drive strobe with drv_addr equal to the offset and drv_width = 0 (byte).
- R2: A 2-byte or 4-byte task-file access at offset 0 raises one drive strobe at drv_addr 0, with drv_width = 1 (word) or 2 (doubleword). A doubleword access is not split.
- R3: A 2-byte or 4-byte task-file access at any nonzero offset is dropped and raises no drive strobe.
- R4: In the control window only a 1-byte access at offset 2 is honoured. It is forwarded to drv_addr 12, which is 8 + offset + 2. A read there returns the alternate status, and a write lands in the device-control register.
- R5: An illegal read returns 0xFF for size 1, 0xFFFF for size 2 and 0xFFFFFFFF for size 4. Size codes other than 1, 2 and 4 are illegal for every window and offset, and a read with such a code returns 0xFFFFFFFF.
- R6: An illegal write raises no drive strobe and leaves every drive register unchanged.
- R7: host_rvalid is high in the cycle after every host read, legal or not, and low after any cycle without a read. host_rdata is valid while host_rvalid is high.
- R8: Legal read data is zero above the access width. Drive write data is forced to zero above the access width, and host byte 0 maps to bits 7:0.
- R9: A cycle with both host_rd and host_wr high is dropped. It raises no drive strobe, and its read returns all ones of the access width.
- R10: While reset is held, and after it, host_rvalid and host_rdata are 0 and no drive strobe is raised when no host strobe is present.
- R11: At most one of drv_rd and drv_wr is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_win | input | 1 | Window select: 0 task file, 1 control |
| host_off | input | 3 | Byte offset inside the window |
| host_size | input | 3 | Access size in bytes (1, 2, 4) |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data, little-endian |
| host_rdata | output | 32 | Read data, one cycle after the strobe |
| host_rvalid | output | 1 | Read data valid |
| drv_addr | output | 4 | Drive register address (0..7 task file, 12 control) |
| drv_width | output | 2 | Transfer width: 0 byte, 1 word, 2 doubleword |
| drv_rd | output | 1 | Drive read strobe |
| drv_wr | output | 1 | Drive write strobe |
| drv_wdata | output | 32 | Drive write data, zero above width |
| drv_rdata | input | 32 | Drive read data, combinational on drv_rd |

## Verification
The hardest case to reach from the ports is an illegal write that leaves the drive state untouched. The host cannot see that state directly. It only shows up when a later legal read of the same register returns the earlier value. The stimulus therefore seeds every register with known data, then issues wide writes at odd offsets, control writes at every offset other than 2, unusual size codes, and combined read-and-write cycles. Legal byte and wide reads follow, and the reference model compares them every clock. A long pseudo-random tail mixes all windows, offsets and size codes back to back, so that dropped accesses sit directly next to honoured ones.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int HOST_DW = 32;

  typedef enum logic [1:0] {
    XW_BYTE  = 2'd0,
    XW_WORD  = 2'd1,
    XW_DWORD = 2'd2
  } xfer_w_e;

  // Bit mask covering the requested access width; odd codes cover the full bus.
  function automatic logic [HOST_DW-1:0] lane_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    lane_mask = 32'h0000_00FF;
      3'd2:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic xfer_w_e size_to_w(input logic [2:0] sz);
    case (sz)
      3'd2:    size_to_w = XW_WORD;
      3'd4:    size_to_w = XW_DWORD;
      default: size_to_w = XW_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/ide_acc_check.sv
module ide_acc_check
  import ide_dec_pkg::*;
#(
  parameter int OFF_W     = 3,
  parameter int TF_BYTES  = 8,
  parameter int CTL_PORT  = 2,
  parameter int CTL_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win,
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       size,
  input  logic             rd,
  input  logic             wr,
  output logic             fwd_rd,
  output logic             fwd_wr,
  output logic [OFF_W:0]   acc_addr,
  output logic [1:0]       acc_width
);

  localparam logic [OFF_W-1:0] CTL_PORT_V = OFF_W'(CTL_PORT);
  localparam logic [OFF_W-1:0] CTL_DEST_V = OFF_W'(CTL_PORT + CTL_SHIFT);

  logic size_byte, size_wide, tf_in_win, tf_ok, ctl_ok, legal;

  assign size_byte = (size == 3'd1);
  assign size_wide = (size == 3'd2) || (size == 3'd4);

  generate
    if (TF_BYTES >= (1 << OFF_W)) begin : g_tf_full
      assign tf_in_win = 1'b1;
    end else begin : g_tf_part
      assign tf_in_win = (off < OFF_W'(TF_BYTES));
    end
  endgenerate

  assign tf_ok  = !win && tf_in_win && (size_byte || (size_wide && off == '0));
  assign ctl_ok = win && size_byte && (off == CTL_PORT_V);
  assign legal  = tf_ok || ctl_ok;

  assign fwd_rd    = legal && rd && !wr;
  assign fwd_wr    = legal && wr && !rd;
  assign acc_addr  = win ? {1'b1, CTL_DEST_V} : {1'b0, off};
  assign acc_width = size_to_w(size);

  // R3: a wide transfer only ever reaches the data port
  p_wide_off0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_rd || fwd_wr) && (acc_width != XW_BYTE) |-> !win && (off == '0));

  // R4: control window forwards only a byte access at the honoured offset
  p_ctl_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_rd || fwd_wr) && win |-> (size == 3'd1) && (off == CTL_PORT_V));

endmodule

// File: rtl/ide_rd_stage.sv
module ide_rd_stage
  import ide_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic               hit,
  input  logic [2:0]         size,
  input  logic [HOST_DW-1:0] drv_rdata,
  output logic               rvalid,
  output logic [HOST_DW-1:0] rdata
);

  localparam int LANES = HOST_DW / 8;

  logic [HOST_DW-1:0] mask, nxt;

  assign mask = lane_mask(size);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign nxt[8*g +: 8] = mask[8*g] ? (hit ? drv_rdata[8*g +: 8] : 8'hFF) : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= nxt;
    end
  end

  // R5: refused read of a word returns exactly sixteen ones
  p_ones_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap && !hit && (size == 3'd2) |=> rdata == 32'h0000_FFFF);

  // R8: byte reads are zero-extended
  p_zext_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap && (size == 3'd1) |=> rdata[31:8] == 24'h0);

endmodule

// File: rtl/ide_drv_model.sv
module ide_drv_model
  import ide_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         addr,
  input  logic [1:0]         width,
  input  logic               rd,
  input  logic               wr,
  input  logic [HOST_DW-1:0] wdata,
  output logic [HOST_DW-1:0] rdata,
  output logic [7:0]         devctl
);

  logic [HOST_DW-1:0] data_q;
  logic [7:0]         tf_q [8];
  logic [7:0]         dc_q;

  assign devctl = dc_q;

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == 4'd0) begin
        case (width)
          XW_WORD:  rdata = {16'h0, data_q[15:0]};
          XW_DWORD: rdata = data_q;
          default:  rdata = {24'h0, data_q[7:0]};
        endcase
      end else if (!addr[3]) begin
        rdata = {24'h0, tf_q[addr[2:0]]};
      end else if (addr == 4'd12) begin
        rdata = {24'h0, tf_q[7]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dc_q   <= '0;
      for (int i = 0; i < 8; i++) tf_q[i] <= '0;
    end else if (wr) begin
      if (addr == 4'd0) begin
        case (width)
          XW_WORD:  data_q[15:0] <= wdata[15:0];
          XW_DWORD: data_q       <= wdata;
          default:  data_q[7:0]  <= wdata[7:0];
        endcase
      end else if (!addr[3]) begin
        tf_q[addr[2:0]] <= wdata[7:0];
      end else if (addr == 4'd12) begin
        dc_q <= wdata[7:0];
      end
    end
  end

endmodule

// File: rtl/ide_chan_decoder.sv
module ide_chan_decoder
  import ide_dec_pkg::*;
#(
  parameter int OFF_W     = 3,
  parameter int TF_BYTES  = 8,
  parameter int CTL_PORT  = 2,
  parameter int CTL_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_win,
  input  logic [OFF_W-1:0]   host_off,
  input  logic [2:0]         host_size,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               host_rvalid,
  output logic [OFF_W:0]     drv_addr,
  output logic [1:0]         drv_width,
  output logic               drv_rd,
  output logic               drv_wr,
  output logic [HOST_DW-1:0] drv_wdata,
  input  logic [HOST_DW-1:0] drv_rdata
);

  logic           fwd_rd, fwd_wr;
  logic [OFF_W:0] acc_addr;
  logic [1:0]     acc_width;

  ide_acc_check #(
    .OFF_W(OFF_W), .TF_BYTES(TF_BYTES), .CTL_PORT(CTL_PORT), .CTL_SHIFT(CTL_SHIFT)
  ) u_check (
    .clk(clk), .rst_n(rst_n), .win(host_win), .off(host_off), .size(host_size),
    .rd(host_rd), .wr(host_wr), .fwd_rd(fwd_rd), .fwd_wr(fwd_wr),
    .acc_addr(acc_addr), .acc_width(acc_width)
  );

  assign drv_rd    = fwd_rd;
  assign drv_wr    = fwd_wr;
  assign drv_addr  = acc_addr;
  assign drv_width = acc_width;
  assign drv_wdata = fwd_wr ? (host_wdata & lane_mask(host_size)) : '0;

  ide_rd_stage u_rd (
    .clk(clk), .rst_n(rst_n), .cap(host_rd), .hit(fwd_rd), .size(host_size),
    .drv_rdata(drv_rdata), .rvalid(host_rvalid), .rdata(host_rdata)
  );

  // R11: a drive access is a read or a write, never both
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_rd, drv_wr}));

  // R9: colliding host strobes never reach the drive
  p_collide_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_wr |-> !drv_rd && !drv_wr);

  // R7: every host read yields a valid beat next cycle, nothing else does
  p_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);
  p_no_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);

  // R6: a write strobe on the drive implies a legal host write
  p_no_stray_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_wr |-> host_wr && !host_rd);

endmodule

// File: tb/tb_ide_chan_decoder.sv
module tb_ide_chan_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_win = 1'b0;
  logic [2:0]  host_off = '0;
  logic [2:0]  host_size = 3'd1;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata, drv_wdata, drv_rdata;
  logic        host_rvalid, drv_rd, drv_wr;
  logic [3:0]  drv_addr;
  logic [1:0]  drv_width;
  logic [7:0]  devctl;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ide_chan_decoder dut (
    .clk(clk), .rst_n(rst_n), .host_win(host_win), .host_off(host_off),
    .host_size(host_size), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .drv_addr(drv_addr), .drv_width(drv_width), .drv_rd(drv_rd), .drv_wr(drv_wr),
    .drv_wdata(drv_wdata), .drv_rdata(drv_rdata)
  );

  ide_drv_model u_drv (
    .clk(clk), .rst_n(rst_n), .addr(drv_addr), .width(drv_width), .rd(drv_rd),
    .wr(drv_wr), .wdata(drv_wdata), .rdata(drv_rdata), .devctl(devctl)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_tf [8];
  logic [31:0] m_dat;
  logic [7:0]  m_dc;
  logic        e_rvalid;
  logic [31:0] e_rdata;

  function automatic bit ok_access(bit w, int o, int s);
    if (w) return (s == 1) && (o == 2);
    if (s == 1) return 1;
    if (s == 2 || s == 4) return o == 0;
    return 0;
  endfunction

  function automatic logic [31:0] ones_of(int s);
    if (s == 1) return 32'hFF;
    if (s == 2) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int width_code(int s);
    return (s == 4) ? 2 : (s == 2) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_tf[i] = 8'h0;
      m_dat = '0; m_dc = '0; e_rvalid = 0; e_rdata = '0;
    end else begin
      bit lg;
      int o, s;
      o = int'(host_off); s = int'(host_size);
      lg = ok_access(host_win, o, s);
      e_rvalid = host_rd;
      if (host_rd) begin
        if (lg && !host_wr) begin
          if (host_win) e_rdata = {24'h0, m_tf[7]};
          else if (o == 0) e_rdata = m_dat & ones_of(s);
          else e_rdata = {24'h0, m_tf[o]};
        end else e_rdata = ones_of(s);
      end
      if (host_wr && !host_rd && lg) begin
        if (host_win) m_dc = host_wdata[7:0];
        else if (o == 0) begin
          if (s == 4) m_dat = host_wdata;
          else if (s == 2) m_dat[15:0] = host_wdata[15:0];
          else m_dat[7:0] = host_wdata[7:0];
        end else m_tf[o] = host_wdata[7:0];
      end
    end
  end

  task automatic chk(bit good, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      bit lg, er, ew;
      int o, s;
      o = int'(host_off); s = int'(host_size);
      lg = ok_access(host_win, o, s);
      er = lg && host_rd && !host_wr;
      ew = lg && host_wr && !host_rd;
      chk(host_rvalid == e_rvalid, "R7 rvalid", 32'(host_rvalid), 32'(e_rvalid));
      if (e_rvalid)
        chk(host_rdata == e_rdata, "R5/R8 rdata", host_rdata, e_rdata);
      chk(drv_rd == er, "R1/R3/R9 drv_rd", 32'(drv_rd), 32'(er));
      chk(drv_wr == ew, "R6/R9 drv_wr", 32'(drv_wr), 32'(ew));
      chk(!(drv_rd && drv_wr), "R11 one strobe", {30'h0, drv_rd, drv_wr}, 32'h0);
      if (er || ew) begin
        logic [3:0] ea;
        ea = host_win ? 4'd12 : {1'b0, host_off};
        chk(drv_addr == ea, "R1/R4 drv_addr", 32'(drv_addr), 32'(ea));
        chk(int'(drv_width) == width_code(s), "R2 drv_width", 32'(drv_width), 32'(width_code(s)));
      end
      if (ew)
        chk(drv_wdata == (host_wdata & ones_of(s)), "R8 drv_wdata", drv_wdata, host_wdata & ones_of(s));
      chk(devctl == m_dc, "R4 devctl", 32'(devctl), 32'(m_dc));
    end
  end

  task automatic acc(bit w, int o, int s, bit r, bit wr, logic [31:0] d);
    @(negedge clk);
    #2;
    host_win = w; host_off = 3'(o); host_size = 3'(s);
    host_rd = r; host_wr = wr; host_wdata = d;
  endtask

  task automatic idle();
    acc(0, 0, 1, 0, 0, 32'h0);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(host_rvalid == 1'b0, "R10 rvalid", 32'(host_rvalid), 0);
    chk(host_rdata == 32'h0, "R10 rdata", host_rdata, 0);
    chk(!drv_rd && !drv_wr, "R10 strobes", {30'h0, drv_rd, drv_wr}, 0);
    #2 rst_n = 1'b1;
    idle();
    // R1: seed and read back all task-file bytes
    for (int i = 1; i < 8; i++) acc(0, i, 1, 0, 1, 32'hAB00_0010 + 32'(i));
    for (int i = 0; i < 8; i++) acc(0, i, 1, 1, 0, 32'h0);
    // R2: word and doubleword at the data port
    acc(0, 0, 4, 0, 1, 32'h1234_5678);
    acc(0, 0, 4, 1, 0, 32'h0);
    acc(0, 0, 2, 0, 1, 32'hFFFF_9ABC);
    acc(0, 0, 4, 1, 0, 32'h0);
    acc(0, 0, 2, 1, 0, 32'h0);
    acc(0, 0, 1, 1, 0, 32'h0);
    // R3/R6: wide accesses at nonzero offsets, then readback
    for (int i = 1; i < 8; i++) acc(0, i, 2, 0, 1, 32'h5555_5555);
    for (int i = 1; i < 8; i++) acc(0, i, 4, 1, 0, 32'h0);
    for (int i = 1; i < 8; i++) acc(0, i, 1, 1, 0, 32'h0);
    // R4: control window
    for (int i = 0; i < 4; i++) acc(1, i, 1, 0, 1, 32'hC0 + 32'(i));
    acc(1, 2, 2, 0, 1, 32'h77);
    acc(1, 2, 4, 1, 0, 32'h0);
    for (int i = 0; i < 4; i++) acc(1, i, 1, 1, 0, 32'h0);
    // R5: bad size codes
    acc(0, 0, 3, 1, 0, 32'h0);
    acc(0, 1, 0, 1, 0, 32'h0);
    acc(0, 0, 7, 0, 1, 32'h0);
    acc(0, 0, 4, 1, 0, 32'h0);
    // R9: colliding strobes
    acc(0, 3, 1, 1, 1, 32'h99);
    acc(1, 2, 1, 1, 1, 32'h99);
    acc(0, 3, 1, 1, 0, 32'h0);
    idle();
    // pseudo-random tail
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      acc(lf[0], int'(lf[3:1]), (lf[6:4] == 3'd5) ? 1 : int'(lf[6:4]),
          lf[7], lf[8] & ~(lf[9] & lf[7]), {lf, lf ^ 16'h3C5A});
    end
    idle();
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule